// File: doc/BRIEF.md
# Table-Driven Lamp Control Sequencer

This block steps through a fixed control program of 32 words, each 64 bits wide, and turns it into control lines for the rest of a lamp-management core. The program is a constant array given as a parameter. To change the behaviour, a new table is supplied and the decode logic stays the same. The sequencer executes one word per clock-enable tick. It uses three resources of its own: a 16-bit accumulator with an adder, a timeout down-counter, and a single-level interrupt unit.

Each word carries a 3-bit command, a jump target, a flag selector, a 16-bit immediate and 36 control bits. The control output always shows the control bits of the word that executed most recently. An interrupt request sends the program to the last table entry. The interrupted address is kept so that a return command can resume there. A request that arrives while the handler is running is held until the handler returns.

Top module: `ctl_seq`

## Requirements
- R1: While reset is low, and on its release, the program address is 0, the control output is 0, the handler indicator is 0, the accumulator is 0 and the timeout counter is 0.
- R2: The sequencer executes a word only in cycles with `ce` high. In a cycle with `ce` low, the address and the control output keep their values.
- R3: Word fields are: bits 63:61 command, 60:56 target, 55:52 flag select, 51:36 immediate, 35:0 control. When a word executes, its bits 35:0 appear on `ctrl` after that edge.
- R4: Command 0 (step) moves to address+1, wrapping from 31 to 0. Command 1 (jump) moves to the target.
- R5: Command 2 moves to the target if `flags[select]` is 1, and to address+1 otherwise.
- R6: Command 3 loads the immediate into the timeout counter and moves to address+1. Command 4 stays at its own address while the counter is non-zero and moves to address+1 once it reads zero. The counter drops by one on each `ce` tick while it is non-zero. After a load of N, the wait word therefore occupies N+1 ticks.
- R7: Command 5 adds the immediate to the accumulator, wrapping modulo 2^16, and moves to address+1.
- R8: Command 6 moves to the target if the accumulator equals the immediate, and to address+1 otherwise.
- R9: On a `ce` tick outside the handler with a request present (any `irq` bit high, or one latched earlier), the word at the current address does not execute. That address is saved, the program moves to 31, `ctrl` is unchanged, and `isr_active` goes to 1.
- R10: A request that arrives while the handler runs, or in a cycle without `ce`, is latched. Command 7 inside the handler returns to the saved address and clears `isr_active`. A latched request is then taken on the next `ce` tick.
- R11: `tmo_done` is 1 exactly when the timeout counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Execution tick |
| flags | input | 16 | Status flags that conditional jumps test |
| irq | input | 4 | Interrupt requests |
| ctrl | output | 36 | Control bits of the last executed word |
| pc | output | 5 | Current program address |
| isr_active | output | 1 | High while the handler runs |
| tmo_done | output | 1 | Timeout counter is zero |

## Verification
Three events can fall on the same `ce` tick: an interrupt request, the execution of the return command, and a request that was latched during the handler. The stimulus raises a request while the handler runs and `ce` is low, so the request can only be latched. The return then executes, and on the very next tick the latched request must re-enter the handler. Another request is raised in a cycle without `ce`, and it must be taken on the following tick. The bench judges each case from `pc`, `ctrl` and `isr_active`. In every case the preempted word must not execute and its control bits must not appear.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [2:0] {
      OP_STEP = 3'd0,
      OP_JMP  = 3'd1,
      OP_JFLG = 3'd2,
      OP_LDT  = 3'd3,
      OP_WAIT = 3'd4,
      OP_ADDI = 3'd5,
      OP_CMPB = 3'd6,
      OP_RETI = 3'd7
   } op_e;
   localparam int OP_W = 3;
endpackage

// File: rtl/seq_tmo.sv
module seq_tmo #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/seq_acc.sv
module seq_acc #(
   parameter int ACC_W = 16,
   parameter int IMM_W = 16,
   parameter bit SAT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [IMM_W-1:0] imm,
   output logic             eq
);
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] sum;
   logic [ACC_W:0]   wide;

   assign wide = {1'b0, acc} + {1'b0, ACC_W'(imm)};

   generate
      if (SAT) begin : g_sat
         assign sum = wide[ACC_W] ? '1 : wide[ACC_W-1:0];
      end else begin : g_wrap
         assign sum = wide[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (add_en) acc <= sum;
   end

   assign eq = (acc == ACC_W'(imm));
endmodule

// File: rtl/seq_irq.sv
module seq_irq #(
   parameter int ADDR_W = 5,
   parameter int IRQ_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic [IRQ_N-1:0]  irq,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic              ret_exec,
   output logic              take,
   output logic              in_isr,
   output logic [ADDR_W-1:0] ret_addr
);
   logic pend;
   logic req_any;

   assign req_any = pend | (|irq);
   assign take    = ce & ~in_isr & req_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         in_isr   <= 1'b0;
         ret_addr <= '0;
      end else begin
         pend <= take ? 1'b0 : req_any;
         if (take) begin
            in_isr   <= 1'b1;
            ret_addr <= cur_pc;
         end else if (ret_exec && in_isr) begin
            in_isr <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
   import seq_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int WORD_W = 64,
   parameter int CTRL_W = 36,
   parameter int IMM_W  = 16,
   parameter int COND_W = 4,
   parameter int IRQ_N  = 4,
   parameter int ACC_W  = 16,
   parameter bit ACC_SAT = 1'b0,
   parameter logic [WORD_W-1:0] PROG [2**ADDR_W] = '{default: '0}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce,
   input  logic [2**COND_W-1:0] flags,
   input  logic [IRQ_N-1:0]     irq,
   output logic [CTRL_W-1:0]    ctrl,
   output logic [ADDR_W-1:0]    pc,
   output logic                 isr_active,
   output logic                 tmo_done
);
   localparam int DEPTH  = 2**ADDR_W;
   localparam int OP_LO  = WORD_W - OP_W;
   localparam int TGT_LO = OP_LO - ADDR_W;
   localparam int CND_LO = TGT_LO - COND_W;
   localparam int IMM_LO = CND_LO - IMM_W;
   localparam logic [ADDR_W-1:0] ISR_ADDR = ADDR_W'(DEPTH - 1);

   generate
      if (IMM_LO != CTRL_W) begin : g_bad_layout
         $error("word fields do not fill WORD_W");
      end
      if (ACC_W < IMM_W) begin : g_bad_acc
         $error("ACC_W must be at least IMM_W");
      end
      if (ADDR_W < 1 || COND_W < 1) begin : g_bad_addr
         $error("ADDR_W and COND_W must be positive");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   op_e               op;
   logic [ADDR_W-1:0] tgt;
   logic [COND_W-1:0] cnd;
   logic [IMM_W-1:0]  imm;
   logic [CTRL_W-1:0] ctl_f;
   logic              take;
   logic              exec;
   logic              acc_eq;
   logic [ADDR_W-1:0] ret_addr;
   logic [ADDR_W-1:0] pc_seq;
   logic [ADDR_W-1:0] pc_nx;

   assign word  = PROG[pc];
   assign op    = op_e'(word[WORD_W-1 -: OP_W]);
   assign tgt   = word[OP_LO-1 -: ADDR_W];
   assign cnd   = word[TGT_LO-1 -: COND_W];
   assign imm   = word[CND_LO-1 -: IMM_W];
   assign ctl_f = word[CTRL_W-1:0];

   assign exec   = ce & ~take;
   assign pc_seq = pc + 1'b1;

   seq_irq #(.ADDR_W(ADDR_W), .IRQ_N(IRQ_N)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce       (ce),
      .irq      (irq),
      .cur_pc   (pc),
      .ret_exec (exec && op == OP_RETI),
      .take     (take),
      .in_isr   (isr_active),
      .ret_addr (ret_addr)
   );

   seq_tmo #(.CNT_W(IMM_W)) u_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ce),
      .load     (exec && op == OP_LDT),
      .load_val (imm),
      .zero     (tmo_done)
   );

   seq_acc #(.ACC_W(ACC_W), .IMM_W(IMM_W), .SAT(ACC_SAT)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .add_en (exec && op == OP_ADDI),
      .imm    (imm),
      .eq     (acc_eq)
   );

   always_comb begin
      pc_nx = pc_seq;
      unique case (op)
         OP_STEP, OP_LDT, OP_ADDI: pc_nx = pc_seq;
         OP_JMP:  pc_nx = tgt;
         OP_JFLG: pc_nx = flags[cnd] ? tgt : pc_seq;
         OP_WAIT: pc_nx = tmo_done ? pc_seq : pc;
         OP_CMPB: pc_nx = acc_eq ? tgt : pc_seq;
         OP_RETI: pc_nx = isr_active ? ret_addr : pc_seq;
         default: pc_nx = pc_seq;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc   <= '0;
         ctrl <= '0;
      end else if (take) begin
         pc <= ISR_ADDR;
      end else if (exec) begin
         pc   <= pc_nx;
         ctrl <= ctl_f;
      end
   end
endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk #(
   parameter int ADDR_W = 5,
   parameter int CTRL_W = 36,
   parameter int IMM_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce,
   input logic [ADDR_W-1:0] pc,
   input logic [CTRL_W-1:0] ctrl,
   input logic              isr_active,
   input logic              tmo_done,
   input logic              take,
   input logic              exec,
   input logic [2:0]        op,
   input logic [ADDR_W-1:0] tgt,
   input logic [IMM_W-1:0]  imm
);
   localparam logic [ADDR_W-1:0] LAST = '1;

   AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> (pc == '0 && ctrl == '0 && !isr_active)); // R1
   AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n) !ce |=> ($stable(pc) && $stable(ctrl))); // R2
   AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (exec && op == 3'd1) |=> pc == $past(tgt)); // R4
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (exec && op == 3'd4 && !tmo_done) |=> $stable(pc)); // R6
   AST_TMO_ARM: assert property (@(posedge clk) disable iff (!rst_n) (exec && op == 3'd3 && imm != '0) |=> !tmo_done); // R6
   AST_ISR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) take |=> (pc == LAST && isr_active && $stable(ctrl))); // R9
   AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n) isr_active |-> !take); // R10
endmodule

bind ctl_seq ctl_seq_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .IMM_W(IMM_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce         (ce),
   .pc         (pc),
   .ctrl       (ctrl),
   .isr_active (isr_active),
   .tmo_done   (tmo_done),
   .take       (take),
   .exec       (exec),
   .op         (op),
   .tgt        (tgt),
   .imm        (imm)
);

// File: tb/sim_ctl_seq.sv
module sim_ctl_seq;
   function automatic logic [63:0] mk(input logic [2:0] op, input logic [4:0] tgt,
                                      input logic [3:0] cnd, input logic [15:0] imm,
                                      input logic [35:0] c);
      return {op, tgt, cnd, imm, c};
   endfunction

   localparam logic [63:0] PRG [32] = '{
      0:  mk(3'd0, 5'd0,  4'd0, 16'd0,     36'h001),
      1:  mk(3'd5, 5'd0,  4'd0, 16'd5,     36'h002),
      2:  mk(3'd6, 5'd4,  4'd0, 16'd5,     36'h003),
      3:  mk(3'd0, 5'd0,  4'd0, 16'd0,     36'hBAD),
      4:  mk(3'd2, 5'd7,  4'd3, 16'd0,     36'h004),
      5:  mk(3'd1, 5'd4,  4'd0, 16'd0,     36'h005),
      7:  mk(3'd3, 5'd0,  4'd0, 16'd3,     36'h007),
      8:  mk(3'd4, 5'd0,  4'd0, 16'd0,     36'h008),
      9:  mk(3'd5, 5'd0,  4'd0, 16'hFFFF,  36'h009),
      10: mk(3'd6, 5'd0,  4'd0, 16'd5,     36'h00A),
      11: mk(3'd1, 5'd11, 4'd0, 16'd0,     36'h00B),
      31: mk(3'd7, 5'd0,  4'd0, 16'd0,     36'hF00),
      default: mk(3'd0, 5'd0, 4'd0, 16'd0, 36'h0)
   };

   // vector: req(4) ce(1) flags(16) irq(4) pc(5) ctrl(36) isr(1) tmo(1)
   function automatic logic [67:0] v(input logic [3:0] r, input logic c, input logic [15:0] f,
                                     input logic [3:0] q, input logic [4:0] p,
                                     input logic [35:0] k, input logic i, input logic t);
      return {r, c, f, q, p, k, i, t};
   endfunction

   localparam int NV = 25;
   localparam logic [67:0] VEC [NV] = '{
      v(4'd3,  1, 16'h0000, 4'h0, 5'd1,  36'h001, 0, 1), // R3 step word
      v(4'd2,  0, 16'h0000, 4'h0, 5'd1,  36'h001, 0, 1), // R2 no tick
      v(4'd7,  1, 16'h0000, 4'h0, 5'd2,  36'h002, 0, 1), // R7 add 5
      v(4'd8,  1, 16'h0000, 4'h0, 5'd4,  36'h003, 0, 1), // R8 equal, branch
      v(4'd5,  1, 16'h0000, 4'h0, 5'd5,  36'h004, 0, 1), // R5 flag low
      v(4'd4,  1, 16'h0000, 4'h0, 5'd4,  36'h005, 0, 1), // R4 jump
      v(4'd5,  1, 16'h0008, 4'h0, 5'd7,  36'h004, 0, 1), // R5 flag 3 high
      v(4'd6,  1, 16'h0000, 4'h0, 5'd8,  36'h007, 0, 0), // R6 load 3
      v(4'd6,  1, 16'h0000, 4'h0, 5'd8,  36'h008, 0, 0), // R6 wait
      v(4'd6,  1, 16'h0000, 4'h0, 5'd8,  36'h008, 0, 0), // R6 wait
      v(4'd2,  0, 16'h0000, 4'h0, 5'd8,  36'h008, 0, 0), // R2 counter frozen
      v(4'd11, 1, 16'h0000, 4'h0, 5'd8,  36'h008, 0, 1), // R11 reaches zero
      v(4'd6,  1, 16'h0000, 4'h0, 5'd9,  36'h008, 0, 1), // R6 wait leaves
      v(4'd7,  1, 16'h0000, 4'h0, 5'd10, 36'h009, 0, 1), // R7 add wraps to 4
      v(4'd8,  1, 16'h0000, 4'h0, 5'd11, 36'h00A, 0, 1), // R8 not equal
      v(4'd4,  1, 16'h0000, 4'h0, 5'd11, 36'h00B, 0, 1), // R4 self jump
      v(4'd9,  1, 16'h0000, 4'h1, 5'd31, 36'h00B, 1, 1), // R9 entry
      v(4'd10, 0, 16'h0000, 4'h2, 5'd31, 36'h00B, 1, 1), // R10 latched in handler
      v(4'd10, 1, 16'h0000, 4'h0, 5'd11, 36'hF00, 0, 1), // R10 return
      v(4'd10, 1, 16'h0000, 4'h0, 5'd31, 36'hF00, 1, 1), // R10 latched taken
      v(4'd10, 1, 16'h0000, 4'h0, 5'd11, 36'hF00, 0, 1), // R10 return again
      v(4'd4,  1, 16'h0000, 4'h0, 5'd11, 36'h00B, 0, 1), // R4 resumes
      v(4'd10, 0, 16'h0000, 4'h4, 5'd11, 36'h00B, 0, 1), // R10 request without tick
      v(4'd9,  1, 16'h0000, 4'h0, 5'd31, 36'h00B, 1, 1), // R9 latched entry
      v(4'd10, 1, 16'h0000, 4'h0, 5'd11, 36'hF00, 0, 1)  // R10 return
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce = 1'b0;
   logic [15:0] flags = '0;
   logic [3:0]  irq = '0;
   logic [35:0] ctrl;
   logic [4:0]  pc;
   logic        isr_active;
   logic        tmo_done;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ctl_seq #(.PROG(PRG)) u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .flags(flags), .irq(irq),
      .ctrl(ctrl), .pc(pc), .isr_active(isr_active), .tmo_done(tmo_done)
   );

   task automatic check(input int req, input string what, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic [15:0] f, input logic [3:0] q);
      @(negedge clk);
      ce = c; flags = f; irq = q;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #1;
      check(1, "reset pc", 36'(pc), 36'd0);          // R1
      check(1, "reset ctrl", ctrl, 36'd0);           // R1
      check(1, "reset isr", 36'(isr_active), 36'd0); // R1
      check(11, "reset tmo_done", 36'(tmo_done), 36'd1); // R11
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         logic [67:0] e;
         e = VEC[i];
         step(e[63], e[62:47], e[46:43]);
         check(int'(e[67:64]), $sformatf("vec %0d pc", i), 36'(pc), 36'(e[42:38]));
         check(int'(e[67:64]), $sformatf("vec %0d ctrl", i), ctrl, e[37:2]);
         check(int'(e[67:64]), $sformatf("vec %0d isr", i), 36'(isr_active), 36'(e[1]));
         check(int'(e[67:64]), $sformatf("vec %0d tmo", i), 36'(tmo_done), 36'(e[0]));
      end
      // R1: mid-run reset, then accumulator must restart from zero
      step(1, 16'h0, 4'h0);
      step(1, 16'h0, 4'h0);
      @(negedge clk);
      ce = 1'b0;
      rst_n = 1'b0;
      #1;
      check(1, "mid reset pc", 36'(pc), 36'd0);
      check(1, "mid reset ctrl", ctrl, 36'd0);
      check(1, "mid reset isr", 36'(isr_active), 36'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1, 16'h0, 4'h0);
      step(1, 16'h0, 4'h0);
      step(1, 16'h0, 4'h0);
      check(1, "acc cleared: branch taken", 36'(pc), 36'd4); // R1 with R8
      check(8, "branch word ctrl", ctrl, 36'h003);           // R8
      // R4: wrap from 31 to 0 via handler region is step word at 31? use interrupt then ce
      step(1, 16'h0, 4'h0);
      check(5, "flag low again", 36'(pc), 36'd5);            // R5
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule